// File: doc/BRIEF.md
# Boot Mode Latch for Reset Sequencing

This block records which way the chip should boot. It takes the level on two boot-strap pins while the external reset pin is held low. The reset sequencer raises a one-cycle freeze pulse a fixed number of reference-clock cycles before it releases that pin. From the freeze onward the recorded value no longer follows the pins. When the sequencer enters its third phase, it strobes the block, and the recorded value moves to the boot-mode output together with a valid flag.

The recorded value outlives the reset that produced it. A later reset sequence that never pulls the external pin low strobes phase three again and receives the same value. The pins are not looked at during such a sequence. If the sequencer does pull the external pin low, the pins are recorded afresh. The pins are asynchronous to the reference clock, so they pass through a synchroniser before they are recorded. A separate power-on reset clears everything, and the valid flag stays low until the first capture has finished.

Top module: `boot_mode_capture`

## Requirements
- R1: While `porN` is low, `bootMode` reads 0 and `bootValid` reads 0.
- R2: Each boot pin passes through two flip-flops before it is recorded. A pin change applied in the cycle just before the freeze pulse does not reach the recorded value.
- R3: While `rstExtN` is low and no freeze has been seen, the recorded value follows the synchronised pins on every clock.
- R4: A `freezePulse` seen while `rstExtN` is low stops recording. Later pin changes leave the recorded value alone until `rstExtN` goes high.
- R5: A `phase3Strobe` that is accepted copies the recorded value to `bootMode` and sets `bootValid` on the next clock edge. `bootValid` then stays high until power-on reset.
- R6: A `phase3Strobe` given before any freeze has completed a capture has no effect, so `bootValid` stays 0.
- R7: While `rstExtN` is high, the pins are ignored. Repeated `phase3Strobe` pulses without the external pin return the value from the last capture.
- R8: Pulling `rstExtN` low again starts a new recording. After its freeze, the next accepted strobe delivers the new value.
- R9: A `phase3Strobe` that arrives while `rstExtN` is low and recording is still running leaves both outputs unchanged.
- R10: When `freezePulse` and `phase3Strobe` occur in the same cycle with `rstExtN` low, the output receives the value held at that freeze.
- R11: A `freezePulse` while `rstExtN` is high has no effect. It neither completes a capture nor changes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstExtN | input | 1 | Level of the external reset pin, low means asserted |
| freezePulse | input | 1 | One-cycle pulse from the sequencer at the freeze point |
| phase3Strobe | input | 1 | One-cycle pulse when the sequencer enters phase three |
| bootPins | input | 2 | Raw boot-strap pins, asynchronous |
| bootMode | output | 2 | Boot mode presented to the sequencer |
| bootValid | output | 1 | High once a captured value has been delivered |

## Verification
The freeze and the phase-three copy can fall in the same cycle. The copy must then take the held value, with the freeze taking effect first. A directed sequence provokes this by asserting both pulses on one edge during an external reset, with pins that differ from the held value. The random phase also produces the collision. The bench judges the result against a cycle model built from the requirements and compares `bootMode` and `bootValid` after every edge.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic sampleEn;   // record the synchronised pins this cycle
    logic copyEn;     // move the recorded value to the output
  } bmStrobes_t;
endpackage

// File: rtl/boot_mode_sync.sv
module boot_mode_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) stageQ[s] <= '0;
        else if (s == 0) stageQ[s] <= asyncIn;
        else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
  import boot_mode_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       rstExtN,
  input  logic       freezePulse,
  input  logic       phase3Strobe,
  output bmStrobes_t strobes
);
  logic rstActive;
  logic frozenQ;
  logic doneQ;
  logic freezeNow;
  logic holdOk;

  assign rstActive = !rstExtN;
  assign freezeNow = rstActive && freezePulse;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      frozenQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      frozenQ <= rstActive && (frozenQ || freezePulse);
      doneQ   <= doneQ || freezeNow;
    end
  end

  // Value is stable when the pin is released, or when it is frozen (now or earlier)
  assign holdOk = !rstActive || frozenQ || freezeNow;

  always_comb begin
    strobes          = '0;
    strobes.sampleEn = rstActive && !frozenQ && !freezePulse;
    strobes.copyEn   = phase3Strobe && holdOk && (doneQ || freezeNow);
  end
endmodule

// File: rtl/boot_mode_datapath.sv
module boot_mode_datapath
  import boot_mode_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  bmStrobes_t       strobes,
  input  logic [WIDTH-1:0] pinSync,
  output logic [WIDTH-1:0] modeOut,
  output logic             validOut
);
  logic [WIDTH-1:0] sampleQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sampleQ  <= '0;
      modeOut  <= '0;
      validOut <= 1'b0;
    end else begin
      if (strobes.sampleEn) sampleQ <= pinSync;
      if (strobes.copyEn) begin
        modeOut  <= sampleQ;
        validOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_mode_capture.sv
module boot_mode_capture
  import boot_mode_pkg::*;
#(
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstExtN,
  input  logic              freezePulse,
  input  logic              phase3Strobe,
  input  logic [MODE_W-1:0] bootPins,
  output logic [MODE_W-1:0] bootMode,
  output logic              bootValid
);
  logic [MODE_W-1:0] pinSync;
  bmStrobes_t        strobes;

  boot_mode_sync #(.WIDTH(MODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .porN(porN), .asyncIn(bootPins), .syncOut(pinSync)
  );

  boot_mode_ctrl u_ctrl (
    .clk(clk), .porN(porN), .rstExtN(rstExtN), .freezePulse(freezePulse),
    .phase3Strobe(phase3Strobe), .strobes(strobes)
  );

  boot_mode_datapath #(.WIDTH(MODE_W)) u_dp (
    .clk(clk), .porN(porN), .strobes(strobes), .pinSync(pinSync),
    .modeOut(bootMode), .validOut(bootValid)
  );
endmodule

// File: rtl/boot_mode_capture_chk.sv
module boot_mode_capture_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              porN,
  input logic              rstExtN,
  input logic              freezePulse,
  input logic              phase3Strobe,
  input logic [MODE_W-1:0] bootMode,
  input logic              bootValid
);
  // Independent tracking of freeze/capture state from the port activity
  logic chkFrozen;
  logic chkDone;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      chkFrozen <= 1'b0;
      chkDone   <= 1'b0;
    end else begin
      chkFrozen <= !rstExtN && (chkFrozen || freezePulse);
      chkDone   <= chkDone || (!rstExtN && freezePulse);
    end
  end

  always @(posedge clk) begin
    if (!porN) begin
      assert_reset_state_R1: assert (bootMode == '0 && !bootValid);
    end
  end

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (!porN)
    bootValid |=> bootValid);

  assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!porN)
    !phase3Strobe |=> ($stable(bootMode) && $stable(bootValid)));

  assert_no_valid_early_R6: assert property (@(posedge clk) disable iff (!porN)
    !chkDone |-> !bootValid);

  assert_no_copy_unfrozen_R9: assert property (@(posedge clk) disable iff (!porN)
    (phase3Strobe && !rstExtN && !chkFrozen && !freezePulse)
      |=> ($stable(bootMode) && $stable(bootValid)));
endmodule

bind boot_mode_capture boot_mode_capture_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .porN(porN), .rstExtN(rstExtN), .freezePulse(freezePulse),
  .phase3Strobe(phase3Strobe), .bootMode(bootMode), .bootValid(bootValid)
);

// File: tb/boot_mode_capture_tb.sv
module boot_mode_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       porN, rstExtN, freezePulse, phase3Strobe;
  logic [1:0] bootPins;
  logic [1:0] bootMode;
  logic       bootValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [1:0] mS1, mS2, mSample, mMode;
  logic       mFrozen, mDone, mValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_mode_capture u_dut (
    .clk(clk), .porN(porN), .rstExtN(rstExtN), .freezePulse(freezePulse),
    .phase3Strobe(phase3Strobe), .bootPins(bootPins),
    .bootMode(bootMode), .bootValid(bootValid)
  );

  function automatic bit copyAllowed(input logic act, input logic frz,
                                     input logic fr, input logic dn);
    return (!act || fr || (act && frz)) && (dn || (act && frz));
  endfunction

  // Model one clock edge from the inputs applied before it
  task automatic modelEdge(input logic por, input logic rN, input logic frz,
                           input logic p3, input logic [1:0] pins);
    logic act;
    act = !rN;
    if (!por) begin
      mS1 = 0; mS2 = 0; mSample = 0; mMode = 0;
      mFrozen = 0; mDone = 0; mValid = 0;
    end else begin
      if (p3 && copyAllowed(act, frz, mFrozen, mDone)) begin
        mMode = mSample; mValid = 1'b1;
      end
      if (act && !mFrozen && !frz) mSample = mS2;
      mFrozen = act && (mFrozen || frz);
      mDone   = mDone || (act && frz);
      mS2 = mS1; mS1 = pins;
    end
  endtask

  task automatic step(input logic por, input logic rN, input logic frz,
                      input logic p3, input logic [1:0] pins, input string tag);
    porN = por; rstExtN = rN; freezePulse = frz; phase3Strobe = p3; bootPins = pins;
    @(posedge clk);
    @(negedge clk);
    modelEdge(por, rN, frz, p3, pins);
    checks++;
    if (bootMode !== mMode || bootValid !== mValid) begin
      fails++;
      $display("FAIL %s: mode=%0d valid=%0b expected mode=%0d valid=%0b",
               tag, bootMode, bootValid, mMode, mValid);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", MAX_CYCLES);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    logic rN, frz, p3;
    logic [1:0] pins;
    seed = 32'h5eed;
    void'($urandom(seed));
    porN = 0; rstExtN = 1; freezePulse = 0; phase3Strobe = 0; bootPins = 0;
    @(negedge clk);
    // R1: power-on reset state
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 2'd3, "R1");
    // R6: strobe before any capture
    step(1, 1, 0, 1, 2'd1, "R6");
    step(1, 1, 0, 0, 2'd1, "R6");
    // R3: record while external reset is active
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 2'd2, "R3");
    // R4: freeze, then pins change
    step(1, 0, 1, 0, 2'd2, "R4");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 2'd1, "R4");
    step(1, 1, 0, 0, 2'd1, "R4");
    // R5: deliver, expect mode 2
    step(1, 1, 0, 1, 2'd1, "R5");
    step(1, 1, 0, 0, 2'd1, "R5");
    // R7: internal-only resets reuse the value, pins ignored
    step(1, 1, 0, 0, 2'd3, "R7");
    step(1, 1, 0, 1, 2'd0, "R7");
    step(1, 1, 0, 1, 2'd3, "R7");
    // R11: freeze while released is ignored
    step(1, 1, 1, 0, 2'd0, "R11");
    step(1, 1, 0, 1, 2'd0, "R11");
    // R9: strobe while recording is running
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 2'd3, "R9");
    step(1, 0, 0, 1, 2'd3, "R9");
    step(1, 0, 0, 0, 2'd3, "R9");
    // R2: a pin change one cycle before the freeze is too late
    step(1, 0, 0, 0, 2'd0, "R2");
    step(1, 0, 1, 0, 2'd0, "R2");
    step(1, 1, 0, 0, 2'd0, "R2");
    // R8: new capture delivered (expect 3)
    step(1, 1, 0, 1, 2'd0, "R8");
    step(1, 1, 0, 0, 2'd0, "R8");
    // R10: freeze and strobe in the same cycle
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 2'd1, "R10");
    step(1, 0, 1, 1, 2'd2, "R10");
    step(1, 0, 0, 0, 2'd2, "R10");
    step(1, 1, 0, 0, 2'd2, "R10");
    // Constrained random traffic
    rN = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) rN = ~rN;
      frz  = ($urandom_range(0, 7) == 0);
      p3   = ($urandom_range(0, 5) == 0);
      pins = 2'($urandom_range(0, 3));
      step(1, rN, frz, p3, pins, "R3 R4 R5 R8 R9 R10");
    end
    // R1 again: power-on reset mid-run
    step(0, 1, 0, 0, 2'd2, "R1");
    step(1, 1, 0, 1, 2'd2, "R1");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule